// File: doc/BRIEF.md
# Single-channel PWM generator with phase-accumulator prescaler

This block produces one pulse-width-modulated channel on two output pins. A 16-bit phase accumulator adds a programmable rate word on every system clock, and each carry out of the accumulator advances a PWM counter. The counter length is 9, 10, 11 or 12 bits, so the PWM frequency is clk × rate / 65536 / 2^bits. The duty is set by a value word that carries a sign bit and a magnitude. A mode word selects the counter length, how the PWM and the sign reach the two pins, and whether a new value is applied at once or held until the end of the current period.

A host programs the block through a simple write-only register port. A per-channel enable input forces both pins low without stopping the counter.

Top module: `pwm_dds_channel`

## Requirements
- R1: After reset both outputs are low, and the rate, mode and value registers are zero, so the outputs stay low until the block is programmed.
- R2: A write with wrAddr 0 loads the value register, wrAddr 1 the mode register and wrAddr 2 the rate register. Writes to any other offset (3 to 7) change nothing.
- R3: Every clock the 16-bit accumulator adds the rate word, and each carry advances the counter by one. A rate of 0x8000 therefore gives one count every 2 clocks and 0x4000 one every 4 clocks. A rate of 0 freezes the counter.
- R4: Mode bits [1:0] set the counter length: 0 gives 9 bits, 1 gives 10, 2 gives 11 and 3 gives 12. One period is 2^bits counts.
- R5: The PWM signal is high while the count is below the magnitude. The magnitude is value bits [16 +: bits], and value bits above that field and below bit 16 are ignored. A magnitude of 0 keeps the PWM low. A full-scale magnitude of 2^bits − 1 is low for one count per period.
- R6: With mode bits [4:3] = 00, output A carries the PWM and output B carries the sign, which is value bit 31 (1 means negative).
- R7: With mode bits [4:3] = 01, output A carries the sign and output B carries the PWM.
- R8: With mode bits [4:3] = 10, output A carries the PWM when the sign is 0 and output B carries it when the sign is 1. The other pin is held low, so the two pins are never high together.
- R9: Mode bits [4:3] = 11 select the pulse-density mode, which is not implemented here. In this mode both outputs are low.
- R10: With mode bit 5 clear, a written value takes effect on the next counter advance. With mode bit 5 set, the value is applied only at the advance that ends a period.
- R11: While chanEnable is low, both outputs are low from the next clock on. The counter keeps running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register word offset |
| wrData | input | 32 | Register write data |
| chanEnable | input | 1 | Channel enable; low forces both pins low |
| outA | output | 1 | Output pin A (registered) |
| outB | output | 1 | Output pin B (registered) |

## Verification
The duty is measured by counting the high cycles over one full PWM period. Because the count does not depend on where the window starts, each setting of counter length, rate, sign and pin mapping gives one exact number to compare. Positive and negative values under each pin mapping separate the direct, swapped and up/down mappings from one another. Zero, full-scale and junk-bit values test the magnitude field extraction, and two rates test the prescaler. A value rewritten just after the PWM has fallen mid-period separates the buffered load from the immediate load. A frozen rate, writes to unused offsets and a dropped enable show that these leave the outputs as required.

// File: rtl/pwm_dds_pkg.sv
package pwm_dds_pkg;
  localparam int SIGN_BIT     = 31;
  localparam int MAG_LSB      = 16;
  localparam int MODE_MAP_LSB = 3;
  localparam int MODE_BUF_BIT = 5;
  localparam int OFS_VALUE    = 0;
  localparam int OFS_MODE     = 1;
  localparam int OFS_RATE     = 2;

  typedef enum logic [1:0] {
    MAP_PWM_DIR = 2'b00,
    MAP_DIR_PWM = 2'b01,
    MAP_UP_DOWN = 2'b10,
    MAP_DENSITY = 2'b11
  } pin_map_e;

  typedef struct packed {
    logic advance;
    logic loadActive;
  } ctrl_strobe_t;
endpackage

// File: rtl/pwm_dds_ctrl.sv
module pwm_dds_ctrl
  import pwm_dds_pkg::*;
#(
  parameter int RATE_W = 16,
  parameter int SEL_W  = 2,
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              atWrap,
  output ctrl_strobe_t      strobe,
  output logic [5:0]        modeReg,
  output logic [RATE_W-1:0] rateReg,
  output logic              shadowSign,
  output logic [CNT_W-1:0]  shadowMag
);
  logic [RATE_W-1:0] phaseAcc;
  logic [RATE_W-1:0] phaseNext;
  logic              phaseCarry;

  assign {phaseCarry, phaseNext} = {1'b0, phaseAcc} + {1'b0, rateReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseAcc   <= '0;
      modeReg    <= '0;
      rateReg    <= '0;
      shadowSign <= 1'b0;
      shadowMag  <= '0;
    end else begin
      phaseAcc <= phaseNext;
      if (wrEn) begin
        case (wrAddr)
          ADDR_W'(OFS_VALUE): begin
            shadowSign <= wrData[SIGN_BIT];
            shadowMag  <= wrData[MAG_LSB +: CNT_W];
          end
          ADDR_W'(OFS_MODE): modeReg <= wrData[5:0];
          ADDR_W'(OFS_RATE): rateReg <= wrData[RATE_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strobe.advance    = phaseCarry;
    strobe.loadActive = phaseCarry & (~modeReg[MODE_BUF_BIT] | atWrap);
  end
endmodule

// File: rtl/pwm_dds_datapath.sv
module pwm_dds_datapath
  import pwm_dds_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int MIN_BITS = 9,
  parameter int CNT_W    = MIN_BITS + (2 ** SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobe_t     strobe,
  input  logic [5:0]       modeReg,
  input  logic             shadowSign,
  input  logic [CNT_W-1:0] shadowMag,
  input  logic             chanEnable,
  output logic             atWrap,
  output logic [CNT_W-1:0] count,
  output logic             activeSign,
  output logic             outA,
  output logic             outB
);
  localparam int SEL_MAX = (2 ** SEL_W) - 1;

  logic [SEL_W-1:0] widthSel;
  logic [CNT_W-1:0] maxCount;
  logic [CNT_W-1:0] activeMag;
  logic [CNT_W-1:0] effMag;
  logic             pwmRaw;
  pin_map_e         pinMap;

  assign widthSel = modeReg[SEL_W-1:0];
  assign maxCount = {CNT_W{1'b1}} >> (SEL_MAX - int'(widthSel));
  assign atWrap   = (count == maxCount);
  assign effMag   = activeMag & maxCount;
  assign pwmRaw   = (count < effMag);
  assign pinMap   = pin_map_e'(modeReg[MODE_MAP_LSB +: 2]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count      <= '0;
      activeMag  <= '0;
      activeSign <= 1'b0;
      outA       <= 1'b0;
      outB       <= 1'b0;
    end else begin
      if (strobe.advance)
        count <= atWrap ? '0 : ((count + 1'b1) & maxCount);
      if (strobe.loadActive) begin
        activeMag  <= shadowMag;
        activeSign <= shadowSign;
      end
      if (!chanEnable) begin
        outA <= 1'b0;
        outB <= 1'b0;
      end else begin
        case (pinMap)
          MAP_PWM_DIR: begin outA <= pwmRaw;     outB <= activeSign; end
          MAP_DIR_PWM: begin outA <= activeSign; outB <= pwmRaw;     end
          MAP_UP_DOWN: begin
            outA <= pwmRaw & ~activeSign;
            outB <= pwmRaw & activeSign;
          end
          default:     begin outA <= 1'b0;       outB <= 1'b0;       end
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_dds_channel.sv
module pwm_dds_channel
  import pwm_dds_pkg::*;
#(
  parameter int RATE_W   = 16,
  parameter int SEL_W    = 2,
  parameter int MIN_BITS = 9,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              chanEnable,
  output logic              outA,
  output logic              outB
);
  localparam int CNT_W = MIN_BITS + (2 ** SEL_W) - 1;

  ctrl_strobe_t      strobe;
  logic [5:0]        modeReg;
  logic [RATE_W-1:0] rateReg;
  logic              shadowSign;
  logic [CNT_W-1:0]  shadowMag;
  logic              atWrap;
  logic [CNT_W-1:0]  count;
  logic              activeSign;

  pwm_dds_ctrl #(
    .RATE_W(RATE_W), .SEL_W(SEL_W), .CNT_W(CNT_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .atWrap(atWrap), .strobe(strobe), .modeReg(modeReg), .rateReg(rateReg),
    .shadowSign(shadowSign), .shadowMag(shadowMag)
  );

  pwm_dds_datapath #(
    .SEL_W(SEL_W), .MIN_BITS(MIN_BITS), .CNT_W(CNT_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modeReg(modeReg),
    .shadowSign(shadowSign), .shadowMag(shadowMag), .chanEnable(chanEnable),
    .atWrap(atWrap), .count(count), .activeSign(activeSign),
    .outA(outA), .outB(outB)
  );
endmodule

// File: rtl/pwm_dds_checker.sv
module pwm_dds_checker #(
  parameter int RATE_W = 16,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              chanEnable,
  input logic [5:0]        modeReg,
  input logic [RATE_W-1:0] rateReg,
  input logic [CNT_W-1:0]  count,
  input logic              activeSign,
  input logic              outA,
  input logic              outB
);
  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !chanEnable |=> (!outA && !outB)); // R11

  AST_DENSITY_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[4:3] == 2'b11) |=> (!outA && !outB)); // R9

  AST_UPDOWN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[4:3] == 2'b10) |=> !(outA && outB)); // R8

  AST_DIR_FOLLOWS_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (chanEnable && modeReg[4:3] == 2'b00) |=> (outB == $past(activeSign))); // R6

  AST_RATE_ZERO_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (rateReg == '0) |=> $stable(count)); // R3
endmodule

bind pwm_dds_channel pwm_dds_checker #(.RATE_W(RATE_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .chanEnable(chanEnable), .modeReg(modeReg),
  .rateReg(rateReg), .count(count), .activeSign(activeSign),
  .outA(outA), .outB(outB)
);

// File: tb/tb_pwm_dds_channel.sv
module tb_pwm_dds_channel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        chanEnable = 1'b0;
  logic        outA, outB;

  int checks = 0;
  int fails  = 0;
  int highA, highB;

  always #10 clk = ~clk;

  pwm_dds_channel dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .chanEnable(chanEnable), .outA(outA), .outB(outB)
  );

  typedef struct packed {
    logic [5:0]  mode;
    logic [15:0] rate;
    logic [31:0] value;
    logic [15:0] win;
    logic [15:0] expA;
    logic [15:0] expB;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [0:NV-1] = '{
    '{6'h00, 16'h8000, 32'h0064_0000, 16'd1024, 16'd200,  16'd0},    // R6 pos
    '{6'h00, 16'h8000, 32'h8064_0000, 16'd1024, 16'd200,  16'd1024}, // R6 neg
    '{6'h08, 16'h8000, 32'h812C_0000, 16'd1024, 16'd1024, 16'd600},  // R7
    '{6'h10, 16'h8000, 32'h0032_0000, 16'd1024, 16'd100,  16'd0},    // R8 pos
    '{6'h10, 16'h8000, 32'h8032_0000, 16'd1024, 16'd0,    16'd100},  // R8 neg
    '{6'h18, 16'h8000, 32'h0064_0000, 16'd1024, 16'd0,    16'd0},    // R9
    '{6'h01, 16'h4000, 32'h03E8_0000, 16'd4096, 16'd4000, 16'd0},    // R4 R3
    '{6'h03, 16'h8000, 32'h0FFF_0000, 16'd8192, 16'd8190, 16'd0},    // R4 R5
    '{6'h00, 16'h8000, 32'h0800_FFFF, 16'd1024, 16'd0,    16'd0},    // R5
    '{6'h20, 16'h8000, 32'h01FF_0000, 16'd1024, 16'd1022, 16'd0},    // R5 R10
    '{6'h02, 16'h8000, 32'h05A5_0000, 16'd4096, 16'd2890, 16'd0}     // R4
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic measure(input int win);
    highA = 0; highB = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      highA += int'(outA);
      highB += int'(outB);
    end
  endtask

  task automatic bufferTest(input logic buffered, input string req);
    logic prevA;
    bit   found;
    regWrite(3'd1, buffered ? 32'h20 : 32'h0);
    regWrite(3'd2, 32'h8000);
    regWrite(3'd0, 32'h0064_0000);
    repeat (3000) @(negedge clk);
    prevA = outA; found = 0;
    for (int i = 0; i < 3000 && !found; i++) begin
      @(negedge clk);
      if (prevA && !outA) found = 1;
      prevA = outA;
    end
    check({req, " falling edge seen"}, int'(found), 1);
    regWrite(3'd0, 32'h0190_0000);
    repeat (20) @(negedge clk);
    check({req, " output just after rewrite"}, int'(outA), buffered ? 0 : 1);
    repeat (1100) @(negedge clk);
    measure(1024);
    check({req, " duty after period end"}, highA, 800);
  endtask

  initial begin
    repeat (100000 * 2) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int transitions;
    logic last;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outA after reset", int'(outA), 0);
    check("R1 outB after reset", int'(outB), 0);
    chanEnable = 1'b1;
    measure(200);
    check("R1 outA unprogrammed", highA, 0);
    check("R1 outB unprogrammed", highB, 0);

    // Table-driven walk over mappings, widths, rates and magnitudes
    for (int v = 0; v < NV; v++) begin
      regWrite(3'd1, {26'd0, VECS[v].mode});
      regWrite(3'd2, {16'd0, VECS[v].rate});
      regWrite(3'd0, VECS[v].value);
      repeat (2 * int'(VECS[v].win)) @(negedge clk);
      measure(int'(VECS[v].win));
      check($sformatf("R4 R5 vector %0d outA", v), highA, int'(VECS[v].expA));
      check($sformatf("R6 R7 R8 R9 vector %0d outB", v), highB, int'(VECS[v].expB));
    end

    // R2: unused offsets change nothing
    regWrite(3'd1, 32'h0);
    regWrite(3'd2, 32'h8000);
    regWrite(3'd0, 32'h0064_0000);
    regWrite(3'd3, 32'h4000);
    regWrite(3'd4, 32'hFFFF_FFFF);
    regWrite(3'd7, 32'h8000_0000);
    repeat (2048) @(negedge clk);
    measure(1024);
    check("R2 outA after unused writes", highA, 200);
    check("R2 outB after unused writes", highB, 0);

    // R3: rate 0 freezes the counter, so the pin never toggles
    regWrite(3'd0, 32'h0100_0000);
    repeat (2048) @(negedge clk);
    regWrite(3'd2, 32'h0);
    repeat (4) @(negedge clk);
    last = outA; transitions = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (outA != last) transitions++;
      last = outA;
    end
    check("R3 toggles with rate zero", transitions, 0);

    // R10: immediate versus period-aligned loading
    bufferTest(1'b0, "R10 unbuffered");
    bufferTest(1'b1, "R10 buffered");

    // R11: enable low silences both pins, counter keeps running
    regWrite(3'd1, 32'h0);
    regWrite(3'd2, 32'h8000);
    regWrite(3'd0, 32'h8064_0000);
    repeat (2048) @(negedge clk);
    chanEnable = 1'b0;
    @(negedge clk);
    measure(1024);
    check("R11 outA disabled", highA, 0);
    check("R11 outB disabled", highB, 0);
    chanEnable = 1'b1;
    repeat (2) @(negedge clk);
    measure(1024);
    check("R11 outA re-enabled", highA, 200);
    check("R11 outB re-enabled", highB, 1024);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule